// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five software localities owns a shared register interface at any moment. Every locality has its own 4 KiB register window. The locality index sits in the address bits above bit 12. Offset zero of each window holds that locality's access register. Software writes this register to ask for ownership or to hand ownership back. Reading it shows whether the register is valid, whether this locality owns the interface, whether its own request is still waiting, and whether another locality is waiting.

The block keeps one owner and a vector of waiting requests. When no locality owns the interface, it grants ownership to the highest-numbered waiting locality. Each grant and each release raises a one-cycle locality-change event for the interrupt logic. Reads are combinational from the address. Writes take effect on the rising clock edge. The owner is also driven out so that the command path can steer its data.

Top module: `loc_arb_top`

## Requirements
- R1: After a synchronous active-low reset, no locality owns the interface, no request waits, and every access register reads 0x80.
- R2: A read of offset 0 in the window of locality 0 to 4 returns bit 7 = 1. A read of any other offset, or of a window numbered 5 or higher, returns 0x00. A write to such an address changes nothing.
- R3: A write to the access register with bit 1 set, from a locality that does not own the interface, marks that locality as waiting. Its access register shows bit 1 = 1 from the next cycle until it is granted.
- R4: When no locality owns the interface and at least one request waits, the highest-numbered waiting locality becomes owner one cycle later. `owner_vld` and `owner_id` show it.
- R5: Bit 5 of the access register reads 1 only in the window of the current owner.
- R6: A write with bit 5 set from the owning locality releases ownership at that clock edge. A waiting request is then granted one cycle later.
- R7: A write with bit 5 set from a locality that does not own the interface is ignored.
- R8: A write with bit 1 set from the owning locality has no effect.
- R9: Bit 2 of a locality's access register reads 1 exactly when some other locality has a request waiting.
- R10: `loc_chg_evt` is high for one cycle, in the cycle after each edge at which ownership was granted or released, and is low otherwise.
- R11: Granting a locality clears its waiting request, so its bit 1 reads 0 while it owns the interface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 16 | Register address: locality in [15:12], offset in [11:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| owner_vld | output | 1 | A locality currently owns the interface |
| owner_id | output | 3 | Index of the owner, meaningful while owner_vld is high |
| loc_chg_evt | output | 1 | One-cycle pulse after each grant or release |

## Verification
Read data depends only on the present state and the address, so it is checked in the same cycle the address is applied. Each write changes the waiting bits and the owner after exactly one edge. A grant that follows a request or a release arrives one edge later still, and `loc_chg_evt` rises on the same edge as the owner change. The bench drives inputs after the falling edge and compares read data shortly after. It moves its reference model at the rising edge, then compares owner and event outputs at the next falling edge. Every cycle therefore compares against the state due after the edge just taken.

// File: rtl/loc_arb_pkg.sv
// Shared constants for the locality arbiter: field positions of the
// per-locality access register. Assumes byte-wide register access.
package loc_arb_pkg;
    localparam int ACC_VLD_BIT  = 7;  // register contents valid
    localparam int ACC_ACT_BIT  = 5;  // this locality owns / release on write
    localparam int ACC_PEND_BIT = 2;  // another locality waits
    localparam int ACC_REQ_BIT  = 1;  // request ownership / own request waiting
endpackage

// File: rtl/loc_arb_pick.sv
// Highest-index picker: reports whether any bit of vec is set and the
// index of the most significant set bit. Purely combinational.
module loc_arb_pick #(
    parameter int N    = 5,
    parameter int ID_W = 3
) (
    input  logic [N-1:0]    vec,
    output logic            found,
    output logic [ID_W-1:0] idx
);
    // Scan upward so the highest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/loc_arb_regif.sv
// Register window decode for the arbiter. It splits the address into a
// locality and an offset, turns access-register writes into per-locality
// request and release strobes, and builds the read data from arbiter
// state. Assumes LOC_W >= ID_W and a combinational read path.
module loc_arb_regif
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC   = 5,
    parameter int ADDR_W    = 16,
    parameter int LOC_SHIFT = 12,
    parameter int ID_W      = 3
) (
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic               owner_vld,
    input  logic [ID_W-1:0]    owner_id,
    input  logic [NUM_LOC-1:0] pend_q,
    output logic [NUM_LOC-1:0] req_vec,
    output logic [NUM_LOC-1:0] rel_vec,
    output logic [7:0]         bus_rdata
);
    localparam int LOC_W = ADDR_W - LOC_SHIFT;

    logic [LOC_W-1:0]     win_sel;
    logic [LOC_SHIFT-1:0] win_off;
    logic [NUM_LOC-1:0]   sel_mask;
    logic                 acc_hit;

    assign win_sel = bus_addr[ADDR_W-1:LOC_SHIFT];
    assign win_off = bus_addr[LOC_SHIFT-1:0];

    // One-hot window select, one comparator per locality.
    for (genvar l = 0; l < NUM_LOC; l++) begin : g_sel
        assign sel_mask[l] = (win_sel == LOC_W'(l));
    end

    assign acc_hit = (win_off == '0) && (|sel_mask);

    // Write strobes toward the arbiter core.
    always_comb begin
        req_vec = (bus_wr && acc_hit && bus_wdata[ACC_REQ_BIT]) ? sel_mask : '0;
        rel_vec = (bus_wr && acc_hit && bus_wdata[ACC_ACT_BIT]) ? sel_mask : '0;
    end

    // Read data assembly for the selected access register.
    always_comb begin
        bus_rdata = 8'h00;
        if (acc_hit) begin
            bus_rdata[ACC_VLD_BIT]  = 1'b1;
            bus_rdata[ACC_ACT_BIT]  = owner_vld && (LOC_W'(owner_id) == win_sel);
            bus_rdata[ACC_PEND_BIT] = |(pend_q & ~sel_mask);
            bus_rdata[ACC_REQ_BIT]  = |(pend_q & sel_mask);
        end
    end

    // R3: a single write strobes at most one locality
    always_comb begin
        req_onehot_chk : assert ($onehot0(req_vec));
    end
endmodule

// File: rtl/loc_arb_core.sv
// Ownership state of the arbiter: the waiting-request vector, the owner,
// and the change event. Grants only while nobody owns the interface,
// choosing the highest-numbered waiting locality; ignores requests from
// the owner and releases from non-owners. Synchronous active-low reset.
module loc_arb_core #(
    parameter int NUM_LOC = 5,
    parameter int ID_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LOC-1:0] req_vec,
    input  logic [NUM_LOC-1:0] rel_vec,
    output logic [NUM_LOC-1:0] pend_q,
    output logic               owner_vld,
    output logic [ID_W-1:0]    owner_id,
    output logic               loc_chg_evt
);
    logic [NUM_LOC-1:0] own_mask, req_eff, grant_mask;
    logic               rel_hit, grant, pick_found;
    logic [ID_W-1:0]    pick_idx;

    loc_arb_pick #(.N(NUM_LOC), .ID_W(ID_W)) u_pick (
        .vec   (pend_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Qualify strobes against the current owner and form the grant.
    always_comb begin
        own_mask   = owner_vld ? (NUM_LOC'(1) << owner_id) : '0;
        rel_hit    = |(rel_vec & own_mask);
        req_eff    = req_vec & ~own_mask;
        grant      = !owner_vld && pick_found;
        grant_mask = grant ? (NUM_LOC'(1) << pick_idx) : '0;
    end

    // State update: waiting set, owner and change event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= '0;
            owner_vld   <= 1'b0;
            owner_id    <= '0;
            loc_chg_evt <= 1'b0;
        end else begin
            pend_q      <= (pend_q | req_eff) & ~grant_mask;
            loc_chg_evt <= grant | rel_hit;
            if (grant) begin
                owner_vld <= 1'b1;
                owner_id  <= pick_idx;
            end else if (rel_hit) begin
                owner_vld <= 1'b0;
            end
        end
    end

    // R4: ownership only appears when a request was waiting
    grant_src_chk : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owner_vld) |-> ($past(pend_q) != '0));

    // R7: an owner never hands over directly to another locality
    owner_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (owner_vld && $past(owner_vld)) |-> (owner_id == $past(owner_id)));

    // R11: the owner never has a waiting request of its own
    owner_nopend_chk : assert property (@(posedge clk) disable iff (!rst_n)
        owner_vld |-> !pend_q[owner_id]);

    // R10: the event marks a change of ownership
    chg_evt_chk : assert property (@(posedge clk) disable iff (!rst_n)
        loc_chg_evt |-> ((owner_vld != $past(owner_vld)) ||
                         (owner_id != $past(owner_id))));

    // R4: a free interface with waiting requests is granted next edge
    grant_due_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_vld && (pend_q != '0)) |=> owner_vld);
endmodule

// File: rtl/loc_arb_top.sv
// Multi-locality access arbiter top: register window decode plus
// ownership core. Assumes a simple single-cycle write strobe and a
// combinational read of the addressed register.
module loc_arb_top #(
    parameter int NUM_LOC   = 5,
    parameter int ADDR_W    = 16,
    parameter int LOC_SHIFT = 12,
    parameter int ID_W      = $clog2(NUM_LOC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              owner_vld,
    output logic [ID_W-1:0]   owner_id,
    output logic              loc_chg_evt
);
    logic [NUM_LOC-1:0] req_vec, rel_vec, pend_q;

    loc_arb_regif #(
        .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT), .ID_W(ID_W)
    ) u_regif (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .owner_vld (owner_vld),
        .owner_id  (owner_id),
        .pend_q    (pend_q),
        .req_vec   (req_vec),
        .rel_vec   (rel_vec),
        .bus_rdata (bus_rdata)
    );

    loc_arb_core #(.NUM_LOC(NUM_LOC), .ID_W(ID_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_vec     (req_vec),
        .rel_vec     (rel_vec),
        .pend_q      (pend_q),
        .owner_vld   (owner_vld),
        .owner_id    (owner_id),
        .loc_chg_evt (loc_chg_evt)
    );
endmodule

// File: tb/loc_arb_top_tb.sv
`timescale 1ns/1ps
module loc_arb_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        owner_vld;
    logic [2:0]  owner_id;
    logic        loc_chg_evt;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state.
    int m_owner = -1;
    bit m_pend[5];
    bit m_evt = 0;

    always #2 clk = ~clk;

    loc_arb_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .owner_vld(owner_vld),
        .owner_id(owner_id), .loc_chg_evt(loc_chg_evt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(input logic [15:0] a);
        int loc = int'(a[15:12]);
        int r = 0;
        if (a[11:0] != 0 || loc >= 5) return 0;
        r = 8'h80;
        if (m_owner == loc) r |= 8'h20;
        for (int j = 0; j < 5; j++) begin
            if (m_pend[j] && j != loc) r |= 8'h04;
        end
        if (m_pend[loc]) r |= 8'h02;
        return r;
    endfunction

    // Advance the model by one clock edge using the applied inputs.
    task automatic model_step(input bit wr, input logic [15:0] a, input logic [7:0] d);
        int loc = int'(a[15:12]);
        bit hit = wr && (a[11:0] == 0) && (loc < 5);
        bit rel = 0;
        int g = -1;
        bit req[5];
        for (int j = 0; j < 5; j++) req[j] = 0;
        if (hit && d[5] && m_owner == loc) rel = 1;
        if (hit && d[1] && m_owner != loc) req[loc] = 1;
        if (m_owner < 0) begin
            for (int j = 0; j < 5; j++) if (m_pend[j]) g = j;
        end
        for (int j = 0; j < 5; j++) m_pend[j] = m_pend[j] | req[j];
        m_evt = 0;
        if (g >= 0) begin
            m_pend[g] = 0;
            m_owner = g;
            m_evt = 1;
        end else if (rel) begin
            m_owner = -1;
            m_evt = 1;
        end
    endtask

    function automatic string rd_tag(input int act, input int exp);
        int x = act ^ exp;
        if (x & 8'h20) return "R5";
        if (x & 8'h04) return "R9";
        if (x & 8'h02) return "R3";
        return "R2";
    endfunction

    // One bus cycle: drive, compare state and read data, then take the edge.
    task automatic cyc(input bit wr, input logic [15:0] a, input logic [7:0] d);
        int exp_rd;
        @(negedge clk);
        chk("R4", int'(owner_vld), int'(m_owner >= 0));
        if (m_owner >= 0) chk("R4", int'(owner_id), m_owner);
        chk("R10", int'(loc_chg_evt), int'(m_evt));
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        #0.5;
        exp_rd = model_read(a);
        chk(rd_tag(int'(bus_rdata), exp_rd), int'(bus_rdata), exp_rd);
        @(posedge clk);
        model_step(wr, a, d);
    endtask

    task automatic rd(input int loc);
        cyc(1'b0, 16'(loc << 12), 8'h00);
    endtask

    task automatic wr_acc(input int loc, input logic [7:0] d);
        cyc(1'b1, 16'(loc << 12), d);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int j = 0; j < 5; j++) m_pend[j] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", int'(owner_vld), 0);
        chk("R1", int'(loc_chg_evt), 0);
        for (int l = 0; l < 5; l++) begin
            rd(l);
            chk("R1", int'(bus_rdata), 8'h80);
        end
        // R3 then R4: single request and grant
        wr_acc(2, 8'h02);
        rd(2);
        rd(2);
        chk("R4", int'(owner_vld), 1);
        chk("R11", int'(bus_rdata[1]), 0);
        // Several waiters while 2 owns
        wr_acc(1, 8'h02);
        wr_acc(4, 8'h02);
        wr_acc(3, 8'h02);
        rd(2);
        // R8: owner re-request ignored
        wr_acc(2, 8'h02);
        rd(2);
        chk("R8", int'(bus_rdata[1]), 0);
        // R7: non-owner release ignored
        wr_acc(4, 8'h20);
        rd(4);
        chk("R7", int'(owner_id), 2);
        // R6: owner release, then highest waiter (4) granted
        wr_acc(2, 8'h20);
        rd(4);
        chk("R6", int'(owner_vld), 0);
        rd(4);
        chk("R4", int'(owner_id), 4);
        // R2: other offsets and windows
        cyc(1'b0, 16'h4018, 8'h00);
        chk("R2", int'(bus_rdata), 0);
        cyc(1'b1, 16'h5000, 8'h22);
        chk("R2", int'(bus_rdata), 0);
        cyc(1'b1, 16'h4004, 8'h20);
        rd(4);
        chk("R2", int'(owner_vld), 1);
        // Drain the rest
        wr_acc(4, 8'h20); rd(0); rd(3);
        wr_acc(3, 8'h22); rd(1); rd(1);
        // Pseudo-random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom_range(0, 99));
            int l = int'($urandom_range(0, 6));
            logic [7:0] d;
            logic [15:0] a;
            case ($urandom_range(0, 4))
                0: d = 8'h02;
                1: d = 8'h20;
                2: d = 8'h22;
                3: d = 8'h00;
                default: d = 8'($urandom);
            endcase
            a = 16'(l << 12);
            if (r < 8) a[11:0] = 12'($urandom_range(1, 4095));
            cyc(r < 55, a, d);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule